// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which DMA channel owns the transfer engine next. Each channel has an enable flag, set by software through a one-cycle set pulse and readable at an output. Each channel also has a high-priority flag, a request that comes either from a peripheral line or from the channel itself when it is a memory-to-memory channel, and a 4-bit rate code R.

The arbiter splits the channels into two groups. A requesting channel in the high group always beats every channel in the default group. Inside a group the lowest index wins. The winner gets a one-hot grant and a valid strobe. The winner keeps the grant while the engine reports completed transfers, and gives it up after 2^R of them. It also gives the grant up as soon as the engine reports that the channel's cycle has ended; in that case the channel's enable flag is cleared at the same edge. After a release, the grant outputs stay low for one cycle, and then a new winner is chosen from the requests present.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, `grant` is all zeros and `grant_vld` and every bit of `ch_en` are 0.
- R2: A 1 on bit i of `en_set` at a clock edge sets `ch_en[i]` at that edge. The bit is cleared at the edge where the engine signals `cycle_end` while channel i holds the grant. If both happen at the same edge, the set wins.
- R3: A channel whose `ch_en` bit is 0 never receives the grant, even when its `per_req` bit is 1.
- R4: A channel with `m2m` = 1 requests as soon as it is enabled, with its `per_req` bit at 0.
- R5: If any enabled, requesting channel has `hi_pri` = 1, the grant goes to a channel with `hi_pri` = 1.
- R6: Within the chosen group, the requesting channel with the lowest index is granted.
- R7: Channel i's rate code is `rate[4i+3:4i]`, and a value above 10 counts as 10. The granted channel keeps the same grant until 2^R `xfer_done` pulses have been seen. At the edge of pulse number 2^R the grant is released.
- R8: `cycle_end` during a grant releases the grant at that edge, whatever the transfer count.
- R9: While `grant_vld` is 0, `grant` is zero and the transfer count is held at zero, so a new grant always starts counting from zero. With no enabled requester, `grant_vld` stays 0.
- R10: When the arbiter is idle and a requester is present at a clock edge, the grant appears at that edge. After a release, `grant_vld` is low for exactly one cycle before the next grant.
- R11: While `grant_vld` is 1, exactly one bit of `grant` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_set | input | NCH | One-cycle pulses that set channel enables |
| hi_pri | input | NCH | Channel belongs to the high-priority group |
| m2m | input | NCH | Channel is memory-to-memory and requests on its own |
| per_req | input | NCH | Peripheral request lines |
| rate | input | NCH*RW | Per-channel rate code R; the grant is held for 2^R transfers |
| xfer_done | input | 1 | The engine completed one transfer for the granted channel |
| cycle_end | input | 1 | The granted channel's cycle is finished |
| ch_en | output | NCH | Channel enable status |
| grant | output | NCH | One-hot grant |
| grant_vld | output | 1 | Grant is valid |

## Verification
A wrong transfer count shows at the ports as a release that comes too early or too late. The drop of `grant_vld` moves away from the edge of pulse 2^R, so it is checked at that exact cycle and also one pulse before. A wrong enable or priority state shows at the first grant after idle: a different channel index appears one cycle after the requests are presented. A lost enable clear shows as the same channel being granted again one cycle after its `cycle_end`.

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH  = 12,
  parameter int RW   = 4,
  parameter int MAXR = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    en_set,
  input  logic [NCH-1:0]    hi_pri,
  input  logic [NCH-1:0]    m2m,
  input  logic [NCH-1:0]    per_req,
  input  logic [NCH*RW-1:0] rate,
  input  logic              xfer_done,
  input  logic              cycle_end,
  output logic [NCH-1:0]    ch_en,
  output logic [NCH-1:0]    grant,
  output logic              grant_vld
);
  localparam int CW = MAXR + 1;

  logic [NCH-1:0] en_q, grant_q;
  logic           vld_q;
  logic [CW-1:0]  cnt_q;
  logic [RW-1:0]  gr_rate;

  wire [NCH-1:0] req   = en_q & (m2m | per_req);
  wire [NCH-1:0] hreq  = req & hi_pri;
  wire [NCH-1:0] pool  = (|hreq) ? hreq : req;
  wire [NCH-1:0] pick  = pool & (~pool + {{(NCH-1){1'b0}}, 1'b1});

  always_comb begin
    gr_rate = '0;
    for (int i = 0; i < NCH; i++)
      if (grant_q[i]) gr_rate = gr_rate | rate[i*RW +: RW];
  end

  wire [RW-1:0] rc     = (gr_rate > RW'(MAXR)) ? RW'(MAXR) : gr_rate;
  wire [CW-1:0] lim    = CW'(1) << rc;
  wire [CW-1:0] cnt_nx = cnt_q + CW'(1);
  wire          rel    = vld_q && (cycle_end || (xfer_done && cnt_nx == lim));
  wire [NCH-1:0] clr   = (vld_q && cycle_end) ? grant_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      grant_q <= '0;
      vld_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      en_q <= (en_q & ~clr) | en_set;
      if (!vld_q) begin
        cnt_q <= '0;
        if (|req) begin
          grant_q <= pick;
          vld_q   <= 1'b1;
        end
      end else if (rel) begin
        grant_q <= '0;
        vld_q   <= 1'b0;
        cnt_q   <= '0;
      end else if (xfer_done) begin
        cnt_q <= cnt_nx;
      end
    end
  end

  assign ch_en     = en_q;
  assign grant     = grant_q;
  assign grant_vld = vld_q;
endmodule

module dma_prio_arb_chk #(
  parameter int NCH = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] grant,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] per_req,
  input logic [NCH-1:0] m2m,
  input logic           grant_vld,
  input logic           xfer_done,
  input logic           cycle_end
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> $countones(grant) == 1); // R11
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld |-> grant == '0); // R9
  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> (grant & ~ch_en) == '0); // R3
  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !xfer_done && !cycle_end) |=> (grant_vld && $stable(grant))); // R7
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && cycle_end) |=> !grant_vld); // R8
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_vld && (ch_en & (m2m | per_req)) == '0) |=> !grant_vld); // R9
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .ch_en(ch_en), .per_req(per_req),
  .m2m(m2m), .grant_vld(grant_vld), .xfer_done(xfer_done), .cycle_end(cycle_end)
);

// File: tb/sim_dma_prio_arb.sv
module sim_dma_prio_arb;
  localparam int NCH = 12;
  localparam int RW  = 4;

  logic              clk = 0, rst_n = 0;
  logic [NCH-1:0]    en_set = '0, hi_pri = '0, m2m = '0, per_req = '0;
  logic [NCH*RW-1:0] rate = '0;
  logic              xfer_done = 0, cycle_end = 0;
  logic [NCH-1:0]    ch_en, grant;
  logic              grant_vld;
  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  dma_prio_arb #(.NCH(NCH), .RW(RW)) u0 (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic enable(logic [NCH-1:0] m);
    en_set = m; tick(); en_set = '0;
  endtask

  task automatic xfer();
    xfer_done = 1; tick(); xfer_done = 0;
  endtask

  task automatic end_cycle(string tag);
    xfer_done = 1; cycle_end = 1; tick(); xfer_done = 0; cycle_end = 0;
    check(tag, {31'd0, grant_vld}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 grant", grant, 0);
    check("R1 vld", grant_vld, 0);
    check("R1 en", ch_en, 0);
  endtask

  task automatic t_mask();
    per_req = 12'h008;
    tick(); tick(); tick();
    check("R3 masked", grant_vld, 0);
    enable(12'h008);
    check("R2 en set", ch_en, 12'h008);
    check("R10 not yet", grant_vld, 0);
    tick();
    check("R10 grant", grant, 12'h008);
    end_cycle("R8 end release");
    check("R2 en clear", ch_en, 0);
    per_req = '0;
    tick(); tick();
    check("R9 idle", {grant_vld, grant}, 0);
  endtask

  task automatic t_m2m();
    m2m = 12'h020;
    enable(12'h020); tick();
    check("R4 m2m grant", grant, 12'h020);
    cycle_end = 1; en_set = 12'h020; tick(); cycle_end = 0; en_set = '0;
    check("R2 set wins", ch_en, 12'h020);
    tick();
    check("R2 regrant", grant, 12'h020);
    end_cycle("R8 m2m end");
    m2m = '0;
  endtask

  task automatic t_prio();
    per_req = 12'h284; hi_pri = 12'h280;
    enable(12'h284); tick();
    check("R5 hi wins", grant, 12'h080);
    end_cycle("R8 end7");
    tick();
    check("R6 hi low index", grant, 12'h200);
    end_cycle("R8 end9");
    tick();
    check("R5 default after", grant, 12'h004);
    end_cycle("R8 end2");
    per_req = 12'h012; hi_pri = '0;
    enable(12'h012); tick();
    check("R6 default low index", grant, 12'h002);
    end_cycle("R8 end1");
    tick();
    check("R6 next", grant, 12'h010);
    end_cycle("R8 end4");
    per_req = '0;
  endtask

  task automatic t_hold();
    m2m = 12'h003; rate = '0; rate[3:0] = 4'd2;
    enable(12'h003); tick();
    check("R7 grant0", grant, 12'h001);
    for (int k = 0; k < 3; k++) xfer();
    check("R7 held after 3", {grant_vld, grant}, {1'b1, 12'h001});
    xfer();
    check("R7 released at 4", grant_vld, 0);
    tick();
    check("R10 regrant after gap", grant, 12'h001);
    for (int k = 0; k < 3; k++) xfer();
    check("R9 count restarted", {grant_vld, grant}, {1'b1, 12'h001});
    xfer(); xfer(); xfer();
    end_cycle("R8 early end");
    tick();
    check("R6 ch1 next", grant, 12'h002);
    end_cycle("R8 end ch1");
    m2m = '0;
  endtask

  task automatic t_rate();
    m2m = 12'h800; rate = '0; rate[47:44] = 4'd15;
    enable(12'h800); tick();
    for (int k = 0; k < 1023; k++) xfer();
    check("R7 clamp held 1023", {grant_vld, grant}, {1'b1, 12'h800});
    xfer();
    check("R7 clamp release 1024", grant_vld, 0);
    tick();
    rate[47:44] = 4'd0;
    xfer();
    check("R7 rate0 one xfer", grant_vld, 0);
    tick();
    end_cycle("R8 end11");
    m2m = '0;
    tick(); tick();
    check("R9 final idle", {grant_vld, grant, ch_en}, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    t_reset();
    rst_n = 1; tick();
    t_reset();
    t_mask();
    t_m2m();
    t_prio();
    t_hold();
    t_rate();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule